// File: doc/BRIEF.md
# Pipelined No-Turnaround Burst SRAM

This block is a synthesizable model of a single-port, fully synchronous static memory whose write data arrives two clock-enabled cycles after the write command. A read and a write therefore both finish in the same pipeline stage. Commands of either kind can follow one another on every cycle with no idle bus cycle between them, and a read always sees every write issued before it.

A command, an address and a start offset load when the advance/load control is low and all three chip enables are active. While the control is high, the block continues the current four-beat burst from an internal two-bit counter. The counter either XORs with or adds to the low two address bits, as set by an order select latched at load time. A single active-low clock enable freezes every register in the block. A sleep input makes the block ignore commands. For a programmable number of enabled cycles after sleep is released, write commands are dropped and flagged. Read data comes from an output register and is marked valid only while the asynchronous output enable is low.

Top module: `nt_burst_sram`

## Requirements
- R1: A command loads only on an enabled edge with adv_ld=0 and ce0_n=0, ce1=1, ce2_n=0. If any enable is inactive on a load cycle, no access occurs and any running burst ends, so later continue cycles access nothing.
- R2: With adv_ld=1 during an active burst, addr and rd_wr are ignored and the burst repeats the loaded command type at the next counter value (1, 2, 3, 0, ...). The counter wraps within the aligned group of four.
- R3: With order_il=1 at load, beat k uses low address bits start XOR k.
- R4: With order_il=0 at load, beat k uses low address bits (start + k) mod 4.
- R5: While cke_n=1, no register changes: burst position, pending writes, read output and error flag all hold.
- R6: Byte lane i (bits i*DATA_W/4 and up) is written only if lane_wr_n[i]=0 on the command cycle. A write with lane_wr_n=4'b1111 leaves the word unchanged.
- R7: rd_wr=0 selects write. Write data on wdata is sampled at the second enabled edge after the command edge, and a read issued on the next cycle returns it.
- R8: rd_wr=1 selects read. Read data appears on rdata after the second enabled edge after the command edge. rdata_oe is high only in that output cycle and only while oe_n=0.
- R9: While sleep=1 on an enabled edge, commands are ignored and no burst stays active.
- R10: For RECOV enabled edges after sleep falls, a write load is discarded and recov_wr_err pulses high for one enabled cycle. Reads are still served.
- R11: After reset, rdata_oe=0, recov_wr_err=0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke_n | input | 1 | Active-low clock enable for the whole block |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 = load new command, 1 = continue burst |
| rd_wr | input | 1 | 1 = read, 0 = write (used on load cycles) |
| lane_wr_n | input | 4 | Per-lane active-low write enables |
| order_il | input | 1 | 1 = XOR burst order, 0 = add-and-wrap order |
| sleep | input | 1 | Standby request |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data, sampled two enabled edges after its command |
| rdata | output | DATA_W | Registered read data |
| rdata_oe | output | 1 | rdata is valid and driven |
| recov_wr_err | output | 1 | Write dropped during the wake-up window |

## Verification
Each access resolves at the second enabled edge after its command. After that edge the bench samples read data and the output-valid flag, and it drives the matching write data during the cycle just before that edge. The wake-up error is due right after the command edge itself. The bench's reference tracks the burst counter and a two-stage queue of pending accesses, and it advances only on enabled edges. Stall cycles therefore shift every expected result by exactly the number of frozen cycles. All samples are taken at the falling edge.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  localparam int BEAT_W = 2;

  // low address bits of a burst beat
  function automatic logic [BEAT_W-1:0] beat_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input logic              xor_order
  );
    return xor_order ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/nt_cmd_ctl.sv
module nt_cmd_ctl
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int RECOV  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              ce2_n,
  input  logic              adv_ld,
  input  logic              rd_wr,
  input  logic              order_il,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  output op_e               iss_op,
  output logic [ADDR_W-1:0] iss_addr,
  output logic              err
);

  localparam int WIN_W = $clog2(RECOV + 1);
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(RECOV);

  logic              act_q, act_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  op_e               bop_q, bop_d;
  logic              il_q, il_d;
  logic [WIN_W-1:0]  win_q, win_d;
  logic              err_q, err_d;
  logic              sel;

  assign sel = !ce0_n && ce1 && !ce2_n;

  always_comb begin
    act_d    = act_q;
    base_d   = base_q;
    beat_d   = beat_q;
    bop_d    = bop_q;
    il_d     = il_q;
    win_d    = win_q;
    err_d    = 1'b0;
    iss_op   = OP_NONE;
    iss_addr = addr;
    if (sleep) begin
      act_d = 1'b0;
      win_d = WIN_LOAD;
    end else begin
      if (win_q != '0) win_d = win_q - WIN_W'(1);
      if (!adv_ld) begin
        if (!sel) begin
          act_d = 1'b0;
        end else if (!rd_wr && (win_q != '0)) begin
          act_d = 1'b0;
          err_d = 1'b1;
        end else begin
          iss_op = rd_wr ? OP_RD : OP_WR;
          act_d  = 1'b1;
          base_d = addr;
          beat_d = BEAT_W'(1);
          bop_d  = rd_wr ? OP_RD : OP_WR;
          il_d   = order_il;
        end
      end else if (act_q) begin
        iss_op   = bop_q;
        iss_addr = {base_q[ADDR_W-1:BEAT_W], beat_offset(base_q[BEAT_W-1:0], beat_q, il_q)};
        beat_d   = beat_q + BEAT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      bop_q  <= OP_NONE;
      il_q   <= 1'b0;
      win_q  <= '0;
      err_q  <= 1'b0;
    end else if (!cke_n) begin
      act_q  <= act_d;
      base_q <= base_d;
      beat_q <= beat_d;
      bop_q  <= bop_d;
      il_q   <= il_d;
      win_q  <= win_d;
      err_q  <= err_d;
    end
  end

  assign err = err_q;

endmodule

// File: rtl/nt_wr_delay.sv
module nt_wr_delay
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  op_e               in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_be_n,
  output op_e               head_op,
  output op_e               out_op,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LANES-1:0]  out_be_n
);

  op_e               st_op   [STAGES];
  logic [ADDR_W-1:0] st_addr [STAGES];
  logic [LANES-1:0]  st_be_n [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    op_e               nxt_op;
    logic [ADDR_W-1:0] nxt_addr;
    logic [LANES-1:0]  nxt_be_n;

    if (g == 0) begin : g_first
      always_comb begin
        nxt_op   = in_op;
        nxt_addr = in_addr;
        nxt_be_n = in_be_n;
      end
    end else begin : g_next
      always_comb begin
        nxt_op   = st_op[g-1];
        nxt_addr = st_addr[g-1];
        nxt_be_n = st_be_n[g-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_op[g] <= OP_NONE;
      else if (!cke_n) st_op[g] <= nxt_op;
    end

    always_ff @(posedge clk) begin
      if (!cke_n) begin
        st_addr[g] <= nxt_addr;
        st_be_n[g] <= nxt_be_n;
      end
    end
  end

  assign head_op  = st_op[0];
  assign out_op   = st_op[STAGES-1];
  assign out_addr = st_addr[STAGES-1];
  assign out_be_n = st_be_n[STAGES-1];

endmodule

// File: rtl/nt_store_core.sv
module nt_store_core
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q,
  output logic              q_vld
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int LW    = DATA_W / LANES;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] q_d;
  logic              vld_d;

  always_ff @(posedge clk) begin
    if (!cke_n && (op == OP_WR)) begin
      for (int l = 0; l < LANES; l++) begin
        if (!be_n[l]) mem[addr][l*LW +: LW] <= wdata[l*LW +: LW];
      end
    end
  end

  always_comb begin
    vld_d = (op == OP_RD);
    q_d   = vld_d ? mem[addr] : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      q_vld <= 1'b0;
    end else if (!cke_n) begin
      q     <= q_d;
      q_vld <= vld_d;
    end
  end

endmodule

// File: rtl/nt_burst_sram.sv
module nt_burst_sram
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36,
  parameter int RECOV  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              ce2_n,
  input  logic              adv_ld,
  input  logic              rd_wr,
  input  logic [3:0]        lane_wr_n,
  input  logic              order_il,
  input  logic              sleep,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              recov_wr_err
);

  localparam int LANES  = 4;
  localparam int STAGES = 2;

  logic [1:0]        rs_q;
  logic              rst_i;
  op_e               iss_op;
  logic [ADDR_W-1:0] iss_addr;
  op_e               head_op;
  op_e               tail_op;
  logic [ADDR_W-1:0] tail_addr;
  logic [LANES-1:0]  tail_be_n;
  logic              q_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  nt_cmd_ctl #(.ADDR_W(ADDR_W), .RECOV(RECOV)) u_ctl (
    .clk(clk), .rst_n(rst_i), .cke_n(cke_n),
    .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
    .adv_ld(adv_ld), .rd_wr(rd_wr), .order_il(order_il), .sleep(sleep),
    .addr(addr), .iss_op(iss_op), .iss_addr(iss_addr), .err(recov_wr_err)
  );

  nt_wr_delay #(.ADDR_W(ADDR_W), .LANES(LANES), .STAGES(STAGES)) u_dly (
    .clk(clk), .rst_n(rst_i), .cke_n(cke_n),
    .in_op(iss_op), .in_addr(iss_addr), .in_be_n(lane_wr_n),
    .head_op(head_op), .out_op(tail_op), .out_addr(tail_addr), .out_be_n(tail_be_n)
  );

  nt_store_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_core (
    .clk(clk), .rst_n(rst_i), .cke_n(cke_n),
    .op(tail_op), .addr(tail_addr), .be_n(tail_be_n), .wdata(wdata),
    .q(rdata), .q_vld(q_vld)
  );

  assign rdata_oe = q_vld && !oe_n;

endmodule

// File: rtl/nt_burst_sram_chk.sv
module nt_burst_sram_chk
  import nt_sram_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke_n,
  input logic              ce0_n,
  input logic              ce1,
  input logic              ce2_n,
  input logic              adv_ld,
  input logic              rd_wr,
  input logic              sleep,
  input logic              oe_n,
  input op_e               head_op,
  input op_e               tail_op,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_oe,
  input logic              err
);

  a_r1_deselect_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld && !(!ce0_n && ce1 && !ce2_n)) |=> (head_op == OP_NONE));

  a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(rdata) && $stable(err) && $stable(tail_op)));

  a_r7_write_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && head_op == OP_WR) |=> (tail_op == OP_WR));

  a_r8_read_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && tail_op == OP_RD) |=> (oe_n || rdata_oe));

  a_r9_sleep_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && sleep) |=> !err);

  a_r10_err_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(!cke_n && !adv_ld && !rd_wr));

endmodule

bind nt_burst_sram nt_burst_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke_n(cke_n),
  .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
  .adv_ld(adv_ld), .rd_wr(rd_wr), .sleep(sleep), .oe_n(oe_n),
  .head_op(head_op), .tail_op(tail_op),
  .rdata(rdata), .rdata_oe(rdata_oe), .err(recov_wr_err)
);

// File: tb/nt_burst_sram_bench.sv
module nt_burst_sram_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int DW    = 36;
  localparam int RECOV = 3;
  localparam int DEPTH = 1 << AW;
  localparam int LW    = DW / 4;
  localparam logic [2:0] SEL = 3'b010; // {ce2_n, ce1, ce0_n}
  localparam logic [2:0] DES = 3'b011;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cke_n, ce0_n, ce1, ce2_n, adv_ld, rd_wr, order_il, sleep, oe_n;
  logic [3:0]    lane_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          rdata_oe, recov_wr_err;

  nt_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .RECOV(RECOV)) u_nt_burst_sram (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
    .adv_ld(adv_ld), .rd_wr(rd_wr), .lane_wr_n(lane_wr_n), .order_il(order_il),
    .sleep(sleep), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe), .recov_wr_err(recov_wr_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int n_step = 0;

  // reference state: 0 none, 1 read, 2 write
  logic [DW-1:0] refm [DEPTH];
  logic [1:0]    p1_op = 2'd0, p2_op = 2'd0, m_op = 2'd0;
  logic [AW-1:0] p1_a, p2_a, m_base;
  logic [3:0]    p1_be, p2_be;
  logic [1:0]    m_beat = 2'd0;
  logic          m_act = 1'b0, m_il = 1'b0, exp_qv = 1'b0, exp_err = 1'b0;
  logic [DW-1:0] exp_q = '0;
  int            m_win = 0;

  // vector: [15] xor order, [14] cke_n, [13] adv_ld, [12] read, [11:8] lane_wr_n, [5:0] addr
  localparam int NV = 49;
  localparam logic [15:0] VEC [NV] = '{
    16'h8000, 16'hB03F, 16'hA015, 16'hB02A,
    16'h0005, 16'h2000, 16'h2000, 16'h2000,
    16'h9002, 16'hA000, 16'hA000, 16'hA000,
    16'h1007, 16'h2000, 16'h2000, 16'h2000,
    16'h0008, 16'h1000, 16'h0009, 16'h1008, 16'h0509, 16'h1009, 16'h1009,
    16'h9001, 16'hA000, 16'h4000, 16'h4000, 16'hA000, 16'hA000,
    16'h9003, 16'hA000, 16'hA000, 16'hA000,
    16'h1004, 16'h2000, 16'h6000, 16'h2000, 16'h2000,
    16'h1006, 16'h2000, 16'h2000, 16'h2000,
    16'h800A, 16'h4000, 16'h4000, 16'h100A, 16'h1008,
    16'h2000, 16'h2000
  };

  function automatic logic [DW-1:0] patt(input int n);
    logic [63:0] t;
    t = {32'(n) * 32'h9E37_79B1, 32'(n) ^ 32'hC3A5_0F1E};
    return t[DW-1:0];
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] s_sel, input logic s_cke_n, input logic s_adv,
                      input logic s_rd, input logic [3:0] s_be, input logic [AW-1:0] s_addr,
                      input logic s_il, input logic s_slp, input logic s_oe_n, input string tag);
    logic [DW-1:0] din;
    logic [1:0]    n_op;
    logic [AW-1:0] n_a;
    logic          n_err;
    din = patt(n_step);
    n_step++;
    {ce2_n, ce1, ce0_n} = s_sel;
    cke_n = s_cke_n; adv_ld = s_adv; rd_wr = s_rd; lane_wr_n = s_be;
    addr = s_addr; order_il = s_il; sleep = s_slp; oe_n = s_oe_n; wdata = din;
    @(posedge clk);
    if (!s_cke_n) begin
      exp_qv = (p2_op == 2'd1);
      if (p2_op == 2'd1) exp_q = refm[p2_a];
      if (p2_op == 2'd2)
        for (int l = 0; l < 4; l++)
          if (!p2_be[l]) refm[p2_a][l*LW +: LW] = din[l*LW +: LW];
      p2_op = p1_op; p2_a = p1_a; p2_be = p1_be;
      n_op = 2'd0; n_a = s_addr; n_err = 1'b0;
      if (s_slp) begin
        m_act = 1'b0; m_win = RECOV;
      end else begin
        if (!s_adv) begin
          if (s_sel != SEL) m_act = 1'b0;
          else if (!s_rd && m_win != 0) begin m_act = 1'b0; n_err = 1'b1; end
          else begin
            n_op = s_rd ? 2'd1 : 2'd2; m_act = 1'b1; m_base = s_addr;
            m_beat = 2'd1; m_op = n_op; m_il = s_il;
          end
        end else if (m_act) begin
          n_op = m_op;
          n_a = {m_base[AW-1:2], m_il ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat)};
          m_beat = m_beat + 2'd1;
        end
        if (m_win != 0) m_win--;
      end
      p1_op = n_op; p1_a = n_a; p1_be = s_be;
      exp_err = n_err;
    end
    @(negedge clk);
    chk(tag, "recov_wr_err", 64'(recov_wr_err), 64'(exp_err));
    chk(tag, "rdata_oe", 64'(rdata_oe), 64'(exp_qv && !s_oe_n));
    if (exp_qv && !s_oe_n) chk(tag, "rdata", 64'(rdata), 64'(exp_q));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(DES, 1'b0, 1'b0, 1'b1, 4'hF, '0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  function automatic string vtag(input logic [15:0] v);
    if (v[14])                return "R5";
    if (v[13])                return v[15] ? "R3" : "R4";
    if (!v[12] && v[11:8] != 4'h0) return "R6";
    return v[12] ? "R8" : "R7";
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {ce2_n, ce1, ce0_n} = DES;
    cke_n = 1'b0; adv_ld = 1'b0; rd_wr = 1'b1; lane_wr_n = 4'hF; addr = '0;
    order_il = 1'b0; sleep = 1'b0; oe_n = 1'b0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11", "rdata_oe", 64'(rdata_oe), 64'd0);
    chk("R11", "recov_wr_err", 64'(recov_wr_err), 64'd0);

    for (int i = 0; i < NV; i++)
      step(SEL, VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:8], VEC[i][AW-1:0],
           VEC[i][15], 1'b0, 1'b0, vtag(VEC[i]));
    idle(3, "R8");

    // R1: writes and continues with one enable inactive reach no word
    step(3'b011, 1'b0, 1'b0, 1'b0, 4'h0, 6'd0, 1'b0, 1'b0, 1'b0, "R1");
    step(3'b000, 1'b0, 1'b0, 1'b0, 4'h0, 6'd1, 1'b0, 1'b0, 1'b0, "R1");
    step(3'b110, 1'b0, 1'b0, 1'b0, 4'h0, 6'd2, 1'b0, 1'b0, 1'b0, "R1");
    step(SEL,    1'b0, 1'b1, 1'b0, 4'h0, 6'd3, 1'b0, 1'b0, 1'b0, "R1");
    step(SEL, 1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 1'b1, 1'b0, 1'b0, "R1");
    step(SEL, 1'b0, 1'b1, 1'b1, 4'hF, 6'd0, 1'b1, 1'b0, 1'b0, "R1");
    step(SEL, 1'b0, 1'b1, 1'b1, 4'hF, 6'd0, 1'b1, 1'b0, 1'b0, "R1");
    idle(3, "R1");

    // R2: six beats from start 1 wrap inside the group
    step(SEL, 1'b0, 1'b0, 1'b1, 4'hF, 6'd1, 1'b1, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 5; i++) step(SEL, 1'b0, 1'b1, 1'b0, 4'h0, 6'd40, 1'b0, 1'b0, 1'b0, "R2");
    idle(3, "R2");

    // R6: write with all lanes off, then read back
    step(SEL, 1'b0, 1'b0, 1'b0, 4'hF, 6'd2, 1'b0, 1'b0, 1'b0, "R6");
    step(SEL, 1'b0, 1'b0, 1'b1, 4'hF, 6'd2, 1'b0, 1'b0, 1'b0, "R6");
    idle(3, "R6");

    // R8: read with output disabled
    step(SEL, 1'b0, 1'b0, 1'b1, 4'hF, 6'd4, 1'b0, 1'b0, 1'b1, "R8");
    step(DES, 1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 1'b0, 1'b0, 1'b1, "R8");
    step(DES, 1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 1'b0, 1'b0, 1'b1, "R8");
    idle(2, "R8");

    // R9 / R10: sleep, then the wake-up window
    step(SEL, 1'b0, 1'b0, 1'b0, 4'h0, 6'd3, 1'b0, 1'b1, 1'b0, "R9");
    step(SEL, 1'b0, 1'b0, 1'b0, 4'h0, 6'd3, 1'b0, 1'b1, 1'b0, "R9");
    step(SEL, 1'b0, 1'b0, 1'b0, 4'h0, 6'd3, 1'b0, 1'b0, 1'b0, "R10");
    step(SEL, 1'b0, 1'b0, 1'b1, 4'hF, 6'd3, 1'b0, 1'b0, 1'b0, "R10");
    idle(1, "R10");
    step(SEL, 1'b0, 1'b0, 1'b0, 4'h0, 6'd3, 1'b0, 1'b0, 1'b0, "R10");
    idle(3, "R10");
    step(SEL, 1'b0, 1'b0, 1'b1, 4'hF, 6'd3, 1'b0, 1'b0, 1'b0, "R10");
    idle(3, "R10");

    summary();
    $finish;
  end

endmodule